// File: doc/BRIEF.md
# Cycle-by-Cycle Overcurrent Limiter

This block sits between a PWM timebase and the power-stage drivers. It watches a one-bit current-sense trip level that an external fixed-threshold comparator produces, and removes all four PWM drive signals for the rest of a switching cycle once an overcurrent is confirmed. The PWM generator marks the start of each switching cycle with a one-clock strobe. That strobe opens a programmable blanking window, during which the trip level is ignored. This keeps the turn-on current spike from cutting the cycle short.

Outside the blanking window, the trip level must stay asserted for a programmable number of consecutive clocks before the block accepts a fault. An accepted fault forces every drive output low from the next clock edge. The outputs come back on their own when the next cycle strobe arrives, and no control can bypass this. A sticky fault flag records that at least one fault was accepted, and a one-clock clear pulse resets it.

Top module: `ocp_cycle_limiter`

## Requirements
- R1: After reset the fault flag reads 0 and every drive output equals its PWM input.
- R2: The blanking window covers the strobe cycle and the following clocks, for a total of 2, 4, 8 or 16 cycles for blank_sel codes 0, 1, 2 and 3. The code is sampled on the strobe. A trip level inside the window is never accepted, however long it lasts.
- R3: A fault is accepted on the Nth consecutive unblanked clock with the trip level high, where N is 1, 2, 4 or 8 for deb_sel codes 0, 1, 2 and 3. A shorter run is rejected.
- R4: A clock with the trip level low restarts the consecutive count from zero.
- R5: A cycle strobe restarts the consecutive count from zero.
- R6: From the clock edge after acceptance, all four drive outputs read 0. They stay at 0 while the strobe is low, whatever the PWM inputs and the trip level do.
- R7: In a clock where the strobe is high, every drive output equals its PWM input, even if a fault was held in the previous cycle.
- R8: The fault flag rises on the same edge that the gating starts. It stays at 1 across later cycle strobes.
- R9: A clear pulse lowers the fault flag at the next edge. If a fault is accepted in the same clock as the clear, the flag stays at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_start | input | 1 | One-clock strobe marking a new switching cycle |
| trip_in | input | 1 | Digitized overcurrent comparator level, 1 = over threshold |
| blank_sel | input | 2 | Blanking length code (R2) |
| deb_sel | input | 2 | Debounce length code (R3) |
| flag_clr | input | 1 | One-clock clear for the fault flag |
| pwm_in | input | 4 | Ungated PWM drive signals |
| pwm_out | output | 4 | Gated PWM drive signals |
| ocp_flag | output | 1 | Sticky fault flag |

## Verification
The in-design assertions check the following on every clock. The count returns to zero after a strobe or a low trip level. The window is open after a strobe. The outputs are dark after an acceptance and pass through during a strobe. The flag follows the gating, and a clear lowers it. The exact lengths of the blanking and debounce windows for each code can only be shown by the bench's scenarios. The same holds for rejection of runs one cycle too short, for stickiness across cycles, and for a clear that collides with an acceptance. There, a behavioural model is compared with the ports on every clock.

// File: rtl/ocl_pkg.sv
`timescale 1ns/1ps
package ocl_pkg;

   typedef logic [1:0] dur_code_t;

   function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                        input int unsigned c, input int unsigned d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

   function automatic int unsigned width_for(input int unsigned v);
      int unsigned w;
      w = 1;
      while ((64'd1 << w) <= 64'(v)) w = w + 1;
      return w;
   endfunction

endpackage

// File: rtl/ocl_blank_timer.sv
`timescale 1ns/1ps
module ocl_blank_timer
   import ocl_pkg::*;
#(
   parameter int unsigned LEN0  = 2,
   parameter int unsigned LEN1  = 4,
   parameter int unsigned LEN2  = 8,
   parameter int unsigned LEN3  = 16,
   parameter int unsigned CNT_W = 5
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      cyc_start,
   input  dur_code_t code,
   output logic      blank_active
);

   localparam logic [CNT_W-1:0] RELOAD0 = CNT_W'(LEN0 - 1);
   localparam logic [CNT_W-1:0] RELOAD1 = CNT_W'(LEN1 - 1);
   localparam logic [CNT_W-1:0] RELOAD2 = CNT_W'(LEN2 - 1);
   localparam logic [CNT_W-1:0] RELOAD3 = CNT_W'(LEN3 - 1);

   logic [CNT_W-1:0] remain_q;
   logic [CNT_W-1:0] reload;

   always_comb begin
      unique case (code)
         2'd0:    reload = RELOAD0;
         2'd1:    reload = RELOAD1;
         2'd2:    reload = RELOAD2;
         default: reload = RELOAD3;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain_q <= '0;
      end else if (cyc_start) begin
         remain_q <= reload;
      end else if (remain_q != '0) begin
         remain_q <= remain_q - 1'b1;
      end
   end

   assign blank_active = cyc_start | (remain_q != '0);

   // R2
   window_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_start && reload != '0) |=> blank_active);

endmodule

// File: rtl/ocl_debounce.sv
`timescale 1ns/1ps
module ocl_debounce
   import ocl_pkg::*;
#(
   parameter int unsigned LEN0  = 1,
   parameter int unsigned LEN1  = 2,
   parameter int unsigned LEN2  = 4,
   parameter int unsigned LEN3  = 8,
   parameter int unsigned CNT_W = 4
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      cyc_start,
   input  logic      qual,
   input  dur_code_t code,
   output logic      accept
);

   localparam logic [CNT_W-1:0] LIM0 = CNT_W'(LEN0 - 1);
   localparam logic [CNT_W-1:0] LIM1 = CNT_W'(LEN1 - 1);
   localparam logic [CNT_W-1:0] LIM2 = CNT_W'(LEN2 - 1);
   localparam logic [CNT_W-1:0] LIM3 = CNT_W'(LEN3 - 1);

   logic [CNT_W-1:0] run_q;
   logic [CNT_W-1:0] limit;

   always_comb begin
      unique case (code)
         2'd0:    limit = LIM0;
         2'd1:    limit = LIM1;
         2'd2:    limit = LIM2;
         default: limit = LIM3;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (cyc_start || !qual) begin
         run_q <= '0;
      end else if (run_q < limit) begin
         run_q <= run_q + 1'b1;
      end
   end

   assign accept = qual & ~cyc_start & (run_q >= limit);

   // R4
   low_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !qual |=> (run_q == '0));

   // R5
   strobe_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_start |=> (run_q == '0));

endmodule

// File: rtl/ocl_fault_hold.sv
`timescale 1ns/1ps
module ocl_fault_hold (
   input  logic clk,
   input  logic rst_n,
   input  logic cyc_start,
   input  logic accept,
   input  logic flag_clr,
   output logic fault_q,
   output logic flag_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fault_q <= 1'b0;
      end else if (cyc_start) begin
         fault_q <= 1'b0;
      end else if (accept) begin
         fault_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (accept) begin
         flag_q <= 1'b1;
      end else if (flag_clr) begin
         flag_q <= 1'b0;
      end
   end

   // R8
   flag_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_q) |-> flag_q);

   // R9
   clear_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && !accept) |=> !flag_q);

endmodule

// File: rtl/ocl_out_gate.sv
`timescale 1ns/1ps
module ocl_out_gate #(
   parameter int unsigned N_OUT = 4
) (
   input  logic             kill,
   input  logic [N_OUT-1:0] drv_in,
   output logic [N_OUT-1:0] drv_out
);

   for (genvar i = 0; i < N_OUT; i++) begin : g_lane
      assign drv_out[i] = drv_in[i] & ~kill;
   end

endmodule

// File: rtl/ocp_cycle_limiter.sv
`timescale 1ns/1ps
module ocp_cycle_limiter
   import ocl_pkg::*;
#(
   parameter int unsigned N_OUT   = 4,
   parameter int unsigned BLANK0  = 2,
   parameter int unsigned BLANK1  = 4,
   parameter int unsigned BLANK2  = 8,
   parameter int unsigned BLANK3  = 16,
   parameter int unsigned DEB0    = 1,
   parameter int unsigned DEB1    = 2,
   parameter int unsigned DEB2    = 4,
   parameter int unsigned DEB3    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cyc_start,
   input  logic             trip_in,
   input  logic [1:0]       blank_sel,
   input  logic [1:0]       deb_sel,
   input  logic             flag_clr,
   input  logic [N_OUT-1:0] pwm_in,
   output logic [N_OUT-1:0] pwm_out,
   output logic             ocp_flag
);

   localparam int unsigned BLANK_MAX = max4(BLANK0, BLANK1, BLANK2, BLANK3);
   localparam int unsigned DEB_MAX   = max4(DEB0, DEB1, DEB2, DEB3);
   localparam int unsigned BCNT_W    = width_for(BLANK_MAX);
   localparam int unsigned DCNT_W    = width_for(DEB_MAX);

   if (N_OUT < 1) begin : g_bad_nout
      $error("ocp_cycle_limiter: N_OUT must be at least 1");
   end
   if (BLANK0 < 1 || BLANK1 < BLANK0 || BLANK2 < BLANK1 || BLANK3 < BLANK2) begin : g_bad_blank
      $error("ocp_cycle_limiter: blanking lengths must be >= 1 and non-decreasing");
   end
   if (DEB0 < 1 || DEB1 < DEB0 || DEB2 < DEB1 || DEB3 < DEB2) begin : g_bad_deb
      $error("ocp_cycle_limiter: debounce lengths must be >= 1 and non-decreasing");
   end

   logic blank_active;
   logic qual;
   logic accept;
   logic fault_q;
   logic kill;

   ocl_blank_timer #(
      .LEN0 (BLANK0), .LEN1 (BLANK1), .LEN2 (BLANK2), .LEN3 (BLANK3),
      .CNT_W(BCNT_W)
   ) u_blank (
      .clk         (clk),
      .rst_n       (rst_n),
      .cyc_start   (cyc_start),
      .code        (blank_sel),
      .blank_active(blank_active)
   );

   assign qual = trip_in & ~blank_active;

   ocl_debounce #(
      .LEN0 (DEB0), .LEN1 (DEB1), .LEN2 (DEB2), .LEN3 (DEB3),
      .CNT_W(DCNT_W)
   ) u_deb (
      .clk      (clk),
      .rst_n    (rst_n),
      .cyc_start(cyc_start),
      .qual     (qual),
      .code     (deb_sel),
      .accept   (accept)
   );

   ocl_fault_hold u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .cyc_start(cyc_start),
      .accept   (accept),
      .flag_clr (flag_clr),
      .fault_q  (fault_q),
      .flag_q   (ocp_flag)
   );

   assign kill = fault_q & ~cyc_start;

   ocl_out_gate #(.N_OUT(N_OUT)) u_gate (
      .kill   (kill),
      .drv_in (pwm_in),
      .drv_out(pwm_out)
   );

   // R6
   dark_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !cyc_start) |=> (cyc_start || pwm_out == '0));

   // R7
   strobe_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_start |-> (pwm_out == pwm_in));

   // R2
   blank_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      blank_active |-> !accept);

endmodule

// File: tb/sim_ocp_cycle_limiter.sv
`timescale 1ns/1ps
module sim_ocp_cycle_limiter;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cyc_start = 1'b0;
   logic       trip_in = 1'b0;
   logic [1:0] blank_sel = 2'd0;
   logic [1:0] deb_sel = 2'd0;
   logic       flag_clr = 1'b0;
   logic [3:0] pwm_in = 4'h0;
   logic [3:0] pwm_out;
   logic       ocp_flag;

   always #2.5 clk = ~clk;

   ocp_cycle_limiter u0 (
      .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .trip_in(trip_in),
      .blank_sel(blank_sel), .deb_sel(deb_sel), .flag_clr(flag_clr),
      .pwm_in(pwm_in), .pwm_out(pwm_out), .ocp_flag(ocp_flag)
   );

   int blk_len [4] = '{2, 4, 8, 16};
   int deb_len [4] = '{1, 2, 4, 8};

   int m_blank = 0;
   int m_run = 0;
   bit m_fault = 0;
   bit m_flag = 0;

   int compared = 0;
   int mismatched = 0;
   string req = "R1";
   int pw_seed = 0;

   task automatic check(input string what, input int act, input int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic step(input bit cs, input bit tr, input bit clr);
      bit blanked, q, acc;
      logic [3:0] pw;
      int exp_out;
      @(negedge clk);
      pw_seed = pw_seed + 5;
      pw = 4'(pw_seed ^ (pw_seed >> 3)) | 4'h1;
      cyc_start = cs; trip_in = tr; flag_clr = clr; pwm_in = pw;
      #1;
      blanked = cs || (m_blank > 0);
      q = tr && !blanked;
      acc = q && !cs && (m_run >= deb_len[deb_sel] - 1);
      exp_out = (m_fault && !cs) ? 0 : int'(pw);
      check("pwm_out", int'(pwm_out), exp_out);
      check("ocp_flag", int'(ocp_flag), int'(m_flag));
      @(posedge clk);
      if (cs) m_blank = blk_len[blank_sel] - 1;
      else if (m_blank > 0) m_blank = m_blank - 1;
      m_run = (cs || !q) ? 0 : m_run + 1;
      if (cs) m_fault = 0;
      else if (acc) m_fault = 1;
      if (acc) m_flag = 1;
      else if (clr) m_flag = 0;
   endtask

   task automatic idle(input int n, input bit tr);
      for (int i = 0; i < n; i++) step(1'b0, tr, 1'b0);
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   endtask

   initial begin
      #(5 * 150000);
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      // R1: reset state
      pwm_in = 4'hA;
      #1;
      check("pwm_out in reset", int'(pwm_out), 'hA);
      check("ocp_flag in reset", int'(ocp_flag), 0);
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      req = "R1"; idle(4, 1'b0);

      // R2: trip held through the 2-cycle window, debounce 1
      req = "R2"; blank_sel = 2'd0; deb_sel = 2'd0;
      step(1'b1, 1'b1, 1'b0); idle(6, 1'b1);
      step(1'b1, 1'b0, 1'b0);
      step(1'b0, 1'b0, 1'b1);
      // R2: 16-cycle window, trip inside only, must be ignored
      blank_sel = 2'd3;
      step(1'b1, 1'b1, 1'b0); idle(15, 1'b1); idle(4, 1'b0);
      // R2: trip starting on the last blanked cycle
      blank_sel = 2'd1;
      step(1'b1, 1'b0, 1'b0); idle(2, 1'b0); idle(5, 1'b1);

      // R3: debounce 4, run of 3 rejected, run of 4 accepted
      req = "R3"; blank_sel = 2'd0; deb_sel = 2'd2;
      step(1'b1, 1'b0, 1'b0); step(1'b0, 1'b0, 1'b1);
      idle(3, 1'b1); idle(2, 1'b0); idle(4, 1'b1); idle(3, 1'b0);
      deb_sel = 2'd3;
      step(1'b1, 1'b0, 1'b0); step(1'b0, 1'b0, 1'b1);
      idle(7, 1'b1); idle(1, 1'b0); idle(8, 1'b1); idle(2, 1'b0);

      // R4: dropout restarts the count
      req = "R4"; deb_sel = 2'd2;
      step(1'b1, 1'b0, 1'b0); step(1'b0, 1'b0, 1'b1);
      idle(2, 1'b1); idle(1, 1'b0); idle(3, 1'b1); idle(1, 1'b0); idle(4, 1'b1);

      // R5: strobe in the middle of a run restarts the count
      req = "R5"; deb_sel = 2'd1; blank_sel = 2'd0;
      step(1'b1, 1'b0, 1'b0); step(1'b0, 1'b0, 1'b1);
      idle(1, 1'b0); idle(1, 1'b1);
      step(1'b1, 1'b1, 1'b0); idle(1, 1'b1); idle(1, 1'b0); idle(3, 1'b1);

      // R6 / R7: gated remainder, release on strobe, varied PWM patterns
      req = "R6"; deb_sel = 2'd0;
      step(1'b1, 1'b0, 1'b0); idle(2, 1'b0); idle(1, 1'b1); idle(8, 1'b0);
      req = "R7";
      step(1'b1, 1'b0, 1'b0); idle(5, 1'b0);
      step(1'b1, 1'b0, 1'b0); idle(1, 1'b0); idle(1, 1'b1);
      step(1'b1, 1'b0, 1'b0);

      // R8: flag sticky across several strobes
      req = "R8";
      idle(3, 1'b0);
      step(1'b1, 1'b0, 1'b0); idle(3, 1'b0);
      step(1'b1, 1'b0, 1'b0); idle(3, 1'b0);

      // R9: clear, then clear colliding with an acceptance
      req = "R9";
      step(1'b0, 1'b0, 1'b1); idle(2, 1'b0);
      idle(1, 1'b0);
      step(1'b0, 1'b1, 1'b1); idle(2, 1'b0);
      step(1'b1, 1'b0, 1'b0); step(1'b0, 1'b0, 1'b1); idle(2, 1'b0);

      finish_run();
   end

endmodule